// File: doc/BRIEF.md
# Serial Back-Channel Message Accumulator

This block collects a status message that a terminal returns over a single attention wire, one bit per display scan line. On every line strobe it samples the wire and shifts the sampled bit into a pair of 16-bit words, an upper word and a lower word. It uses no bit counter. Marker bits travel through the two words. They decide which word takes the next bit and when the message is complete.

Idle lines with the wire low leave the upper word at zero. The first high bit is the start bit, and fifteen more bits follow it into the upper word. The sixteenth upper-word bit must be high to act as a stop mark. The upper word is full when the start bit reaches its least significant bit, and from then on bits go to the lower word. Completion is signalled when a marker that was loaded into the lower word reaches bit 7.

On completion the block presents both words with a one-cycle valid pulse and holds them in a posted state. The next frame start releases that state and clears the upper word, so a new message can begin. For a 24-bit frame F sent with F[0] first, the posted words are upper = F[15:0] and lower = {F[23:16], 8'h80}.

Top module: `bca_accum`

## Requirements
- R1: A synchronous reset, with rst high at a clock edge, clears msg_upper, msg_lower, msg_valid and the posted state.
- R2: The attention input is sampled only in cycles where line_tick is high. A high attn merges a 1 and a low attn merges a 0. Without line_tick, neither word changes.
- R3: While bit 0 of msg_upper is 0, a tick shifts msg_upper right by one and places the sampled bit in bit 15. After reset, one tick with attn high gives msg_upper = 16'h8000.
- R4: Every tick that shifts into the upper word also loads msg_lower with 16'h8000.
- R5: Once bit 0 of msg_upper is 1, ticks leave msg_upper unchanged. They shift msg_lower right by one and place the sampled bit in bit 15.
- R6: Completion requires msg_upper bits 0 and 15 and msg_lower bit 7 to all be 1. When that holds, msg_valid is high for exactly one cycle, on the edge after the completing tick. At that point a 24-bit frame F yields msg_upper = F[15:0] and msg_lower = {F[23:16], 8'h80}.
- R7: After a post, bit 7 of msg_lower stays set. Further ticks change neither word until a frame start.
- R8: A frame_start while posted clears msg_upper to 0 and ends the posted state. A frame_start while not posted has no effect on either word.
- R9: When frame_start and line_tick coincide in the posted state, the tick is dropped. The next tick then begins a new message.
- R10: If bit 15 of msg_upper is 0 when the marker reaches bit 7 of msg_lower, msg_valid stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_tick | input | 1 | One-cycle strobe per scan line |
| frame_start | input | 1 | One-cycle strobe at frame start |
| attn | input | 1 | Serial attention line from the terminal |
| msg_upper | output | 16 | Upper message word |
| msg_lower | output | 16 | Lower message word |
| msg_valid | output | 1 | One-cycle pulse when a message is posted |

## Verification
Each word moves on the same clock edge that samples the tick, so the bench reads both words one time unit after the tick's edge. Completion is detected from registered state, so msg_valid is due one edge later than the last tick. The bench therefore checks that msg_valid is low right after the final tick, high after the next edge, and low again one edge after that. Frame-start effects are checked after the single edge that samples the strobe.

// File: rtl/bca_pkg.sv
package bca_pkg;
    localparam int WORD_W   = 16;
    localparam int MARK_BIT = 7;

    typedef struct packed {
        logic [WORD_W-1:0] upper;
        logic [WORD_W-1:0] lower;
        logic              posted;
        logic              valid;
    } bca_state_t;
endpackage

// File: rtl/bca_bit_sample.sv
module bca_bit_sample #(
    parameter int W = 16
) (
    input  logic         attn,
    output logic [W-1:0] merge_word
);
    always_comb begin
        merge_word        = '0;
        merge_word[W-1]   = attn;
    end
endmodule

// File: rtl/bca_shift_path.sv
module bca_shift_path #(
    parameter int W = 16
) (
    input  logic [W-1:0] upper_q,
    input  logic [W-1:0] lower_q,
    input  logic [W-1:0] merge_word,
    output logic [W-1:0] upper_shift,
    output logic [W-1:0] lower_shift,
    output logic         upper_phase
);
    localparam logic [W-1:0] MARKER = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        upper_phase = ~upper_q[0];
        if (upper_phase) begin
            upper_shift = (upper_q >> 1) | merge_word;
            lower_shift = MARKER;
        end else begin
            upper_shift = upper_q;
            lower_shift = (lower_q >> 1) | merge_word;
        end
    end
endmodule

// File: rtl/bca_frame_detect.sv
module bca_frame_detect #(
    parameter int W        = 16,
    parameter int MARK_POS = 7
) (
    input  logic [W-1:0] upper_q,
    input  logic [W-1:0] lower_q,
    input  logic         posted_q,
    output logic         done
);
    always_comb begin
        done = ~posted_q & upper_q[0] & upper_q[W-1] & lower_q[MARK_POS];
    end
endmodule

// File: rtl/bca_accum.sv
module bca_accum
    import bca_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_tick,
    input  logic              frame_start,
    input  logic              attn,
    output logic [WORD_W-1:0] msg_upper,
    output logic [WORD_W-1:0] msg_lower,
    output logic              msg_valid
);
    bca_state_t        st_d, st_q;
    logic [WORD_W-1:0] merge_word;
    logic [WORD_W-1:0] upper_shift;
    logic [WORD_W-1:0] lower_shift;
    logic              upper_phase;
    logic              done;

    bca_bit_sample #(.W(WORD_W)) u_sample (
        .attn       (attn),
        .merge_word (merge_word)
    );

    bca_shift_path #(.W(WORD_W)) u_shift (
        .upper_q     (st_q.upper),
        .lower_q     (st_q.lower),
        .merge_word  (merge_word),
        .upper_shift (upper_shift),
        .lower_shift (lower_shift),
        .upper_phase (upper_phase)
    );

    bca_frame_detect #(.W(WORD_W), .MARK_POS(MARK_BIT)) u_detect (
        .upper_q  (st_q.upper),
        .lower_q  (st_q.lower),
        .posted_q (st_q.posted),
        .done     (done)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (frame_start && st_q.posted) begin
            st_d.upper  = '0;
            st_d.posted = 1'b0;
        end else if (done) begin
            st_d.posted          = 1'b1;
            st_d.lower[MARK_BIT] = 1'b1;
            st_d.valid           = 1'b1;
        end else if (line_tick && !st_q.posted) begin
            st_d.upper = upper_shift;
            st_d.lower = lower_shift;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msg_upper = st_q.upper;
    assign msg_lower = st_q.lower;
    assign msg_valid = st_q.valid;

    logic unused_phase;
    assign unused_phase = upper_phase;
endmodule

// File: rtl/bca_accum_chk.sv
module bca_accum_chk (
    input logic        clk,
    input logic        rst,
    input logic        line_tick,
    input logic        frame_start,
    input logic [15:0] msg_upper,
    input logic [15:0] msg_lower,
    input logic        msg_valid
);
    logic posted_seen;
    always_ff @(posedge clk) begin
        if (rst) posted_seen <= 1'b0;
        else if (msg_valid) posted_seen <= 1'b1;
        else if (frame_start) posted_seen <= 1'b0;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (msg_upper == 16'h0 && msg_lower == 16'h0 && !msg_valid));

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |=> !msg_valid);

    // R6
    valid_marks_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_upper[0] && msg_upper[15] && msg_lower[7]));

    // R4
    marker_load_chk: assert property (@(posedge clk) disable iff (rst)
        (line_tick && !frame_start && !msg_upper[0] && !posted_seen && !msg_valid
         && !(msg_upper[15] && msg_lower[7]))
        |=> (msg_lower == 16'h8000));

    // R2
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!line_tick && !frame_start) |=> ($stable(msg_upper)));

    // R8
    frame_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start && posted_seen && !msg_valid) |=> (msg_upper == 16'h0));
endmodule

bind bca_accum bca_accum_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_tick   (line_tick),
    .frame_start (frame_start),
    .msg_upper   (msg_upper),
    .msg_lower   (msg_lower),
    .msg_valid   (msg_valid)
);

// File: tb/test_bca_accum.sv
module test_bca_accum;
    logic        clk = 1'b0;
    logic        rst;
    logic        line_tick;
    logic        frame_start;
    logic        attn;
    logic [15:0] msg_upper;
    logic [15:0] msg_lower;
    logic        msg_valid;

    int total = 0;
    int bad   = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    bca_accum i_bca_accum (
        .clk         (clk),
        .rst         (rst),
        .line_tick   (line_tick),
        .frame_start (frame_start),
        .attn        (attn),
        .msg_upper   (msg_upper),
        .msg_lower   (msg_lower),
        .msg_valid   (msg_valid)
    );

    // frame[55:32], expected upper[31:16], expected lower[15:0]
    localparam logic [55:0] VEC [4] = '{
        {24'hA58001, 16'h8001, 16'hA580},
        {24'hFFFFFF, 16'hFFFF, 16'hFF80},
        {24'h00C3A5, 16'hC3A5, 16'h0080},
        {24'h3C9249, 16'h9249, 16'h3C80}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic b);
        attn      = b;
        line_tick = 1'b1;
        @(posedge clk); #1;
        line_tick = 1'b0;
        attn      = 1'b0;
    endtask

    task automatic fstart();
        frame_start = 1'b1;
        @(posedge clk); #1;
        frame_start = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        line_tick = 1'b0; frame_start = 1'b0; attn = 1'b0; rst = 1'b0;
        #2;
        do_reset();
        chk("R1 upper", {16'h0, msg_upper}, 32'h0);
        chk("R1 lower", {16'h0, msg_lower}, 32'h0);
        chk("R1 valid", {31'h0, msg_valid}, 32'h0);

        // table walk: R3 R5 R6 R8
        for (int v = 0; v < 4; v++) begin
            logic [23:0] fr;
            fr = VEC[v][55:32];
            for (int k = 0; k < v; k++) begin
                tick(1'b0); idle(1);
            end
            chk("R2 idle zero upper", {16'h0, msg_upper}, 32'h0);
            for (int b = 0; b < 24; b++) begin
                tick(fr[b]);
                if (b == 0) chk("R3 start bit", {16'h0, msg_upper}, 32'h8000);
                if (b == 15) chk("R4 marker", {16'h0, msg_lower}, 32'h8000);
                if (b < 23) idle(1);
            end
            chk("R6 valid not early", {31'h0, msg_valid}, 32'h0);
            idle(1);
            chk("R6 valid", {31'h0, msg_valid}, 32'h1);
            chk("R6 upper", {16'h0, msg_upper}, {16'h0, VEC[v][31:16]});
            chk("R6 lower", {16'h0, msg_lower}, {16'h0, VEC[v][15:0]});
            idle(1);
            chk("R6 one cycle", {31'h0, msg_valid}, 32'h0);
            tick(1'b1); tick(1'b0);
            chk("R7 upper held", {16'h0, msg_upper}, {16'h0, VEC[v][31:16]});
            chk("R7 lower held", {16'h0, msg_lower}, {16'h0, VEC[v][15:0]});
            fstart();
            chk("R8 clear", {16'h0, msg_upper}, 32'h0);
        end

        // R8: frame start while not posted has no effect
        tick(1'b1); idle(1); tick(1'b1);
        chk("R5 pre upper", {16'h0, msg_upper}, 32'hC000);
        fstart();
        chk("R8 no post upper", {16'h0, msg_upper}, 32'hC000);
        chk("R8 no post lower", {16'h0, msg_lower}, 32'h8000);

        // R5: bits to lower after upper full
        do_reset();
        tick(1'b1);
        for (int b = 1; b < 16; b++) begin idle(1); tick(1'b1); end
        idle(1); tick(1'b1);
        chk("R5 upper frozen", {16'h0, msg_upper}, 32'hFFFF);
        chk("R5 lower shift", {16'h0, msg_lower}, 32'hC000);
        idle(1); tick(1'b0);
        chk("R5 lower zero in", {16'h0, msg_lower}, 32'h6000);

        // R9: coincident frame start and tick while posted
        do_reset();
        for (int b = 0; b < 24; b++) begin tick(1'b1); idle(1); end
        chk("R9 posted", {16'h0, msg_lower}, 32'hFF80);
        attn = 1'b1; line_tick = 1'b1; frame_start = 1'b1;
        @(posedge clk); #1;
        attn = 1'b0; line_tick = 1'b0; frame_start = 1'b0;
        chk("R9 upper", {16'h0, msg_upper}, 32'h0);
        chk("R9 lower", {16'h0, msg_lower}, 32'hFF80);
        tick(1'b1);
        chk("R9 restart upper", {16'h0, msg_upper}, 32'h8000);
        chk("R9 restart lower", {16'h0, msg_lower}, 32'h8000);

        // R10: stop mark missing
        do_reset();
        begin
            int vseen;
            vseen = 0;
            for (int b = 0; b < 24; b++) begin
                tick((b == 15) ? 1'b0 : 1'b1);
                vseen += msg_valid;
                idle(1);
                vseen += msg_valid;
            end
            idle(2);
            vseen += msg_valid;
            chk("R10 no valid", vseen, 32'h0);
        end

        // R1: reset mid message
        tick(1'b1);
        do_reset();
        chk("R1 mid upper", {16'h0, msg_upper}, 32'h0);
        chk("R1 mid lower", {16'h0, msg_lower}, 32'h0);

        // R2: no tick keeps words
        attn = 1'b1;
        idle(3);
        attn = 1'b0;
        chk("R2 no tick", {16'h0, msg_upper}, 32'h0);

        done_flag = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule